// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Unit

This unit sits beside a processor core and decides when a pending device interrupt may take over the running code. Every request line carries a fixed priority level (0 to 4) and a vector address supplied by the device itself. The unit holds the current priority of the running code. A request is eligible only when its level is strictly above that priority, so a handler can be interrupted by more urgent work but never by work at its own level.

When a request wins, the unit acknowledges the device and latches its vector. It then runs a two-write entry sequence on a simple stack port: first the status word (core flags with the current priority in the low bits), then the program counter. The stack grows downward. Finally it raises the current priority to the accepted level and announces the vector. A return input runs the reverse: it reads the program counter, then the status word, and restores the priority that the status word carries. Instruction execution and the stack storage stay outside the unit.

Top module: `irq_accept_top`

## Requirements
- R1: After reset curLevel is 0, ackOut is 0, stkWe and stkRe are 0, and the stack pointer equals STACK_TOP (the first push writes address STACK_TOP-1).
- R2: A request is accepted only when its level is strictly greater than curLevel; a request at or below curLevel gets no acknowledge and stays pending, and a level-0 request is never accepted.
- R3: Among eligible requests the highest level wins; between equal levels the lowest device index wins.
- R4: ackOut is a one-hot pulse, one cycle long, to the winner in the cycle after the decision; from that cycle vectorOut holds the winner's vector.
- R5: Entry makes exactly two stack writes in consecutive cycles: the status word {coreFlags, curLevel} (priority in bits [2:0]) to address sp-1, then pcIn to sp-2; sp ends two lower. The status write happens in the acknowledge cycle.
- R6: In the cycle after the program-counter write, curLevel equals the accepted level and enterPulse is high for one cycle, with vectorOut holding the vector.
- R7: A return reads the program counter at sp, then the status word at sp+1, in consecutive cycles; in the next cycle retDone pulses, retPc and retStatus hold the read values and curLevel equals bits [2:0] of the status word.
- R8: A return request while the stack pointer equals STACK_TOP is ignored: no read, no retDone, no level change.
- R9: When a return request and an eligible interrupt are present in the same idle cycle, the return runs first.
- R10: Requests are only evaluated while idle; no acknowledge is issued during an entry or return sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqLines | input | NUM_DEV | Request line per device, held until acknowledged |
| reqLevels | input | NUM_DEV*LVL_W | Fixed priority level of each device |
| devVectors | input | NUM_DEV*ADDR_W | Vector address held by each device |
| pcIn | input | ADDR_W | Program counter of the interrupted code |
| coreFlags | input | DATA_W-LVL_W | Remaining status-word bits from the core |
| retReq | input | 1 | Return-from-interrupt request |
| ackOut | output | NUM_DEV | One-hot acknowledge to the winning device |
| vectorOut | output | ADDR_W | Latched vector of the accepted request |
| enterPulse | output | 1 | Entry sequence finished |
| curLevel | output | LVL_W | Current priority level |
| stkWe | output | 1 | Stack write strobe |
| stkRe | output | 1 | Stack read strobe |
| stkAddr | output | ADDR_W | Stack address |
| stkWData | output | DATA_W | Stack write data |
| stkRData | input | DATA_W | Stack read data, valid in the same cycle as stkAddr |
| retDone | output | 1 | Return sequence finished |
| retPc | output | ADDR_W | Program counter read back by the return |
| retStatus | output | DATA_W | Status word read back by the return |

## Verification
The acceptance rule is tried with a request above the current level, one equal to it, one below it and one at level 0, which separates a strict comparison from an inclusive one. Nesting two handlers and unwinding them shows that each return restores the level of the interrupted code and lets a previously blocked same-level request through. Simultaneous requests with different levels and with equal levels separate level ordering from index ordering, and a return raised together with an eligible request, plus one raised on an empty stack, pin down the idle-state choice. A higher request raised in the middle of an entry sequence shows that decisions wait for idle.

// File: rtl/irq_accept_pkg.sv
`timescale 1ns/1ps
package irq_accept_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PUSH_ST,
    SEQ_PUSH_PC,
    SEQ_POP_PC,
    SEQ_POP_ST
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchWin;
    logic pushSt;
    logic pushPc;
    logic popPc;
    logic popSt;
  } dpStrobe_t;

endpackage

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int NUM_DEV = 4,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [NUM_DEV-1:0]       reqLines,
  input  logic [NUM_DEV*LVL_W-1:0] reqLevels,
  input  logic [LVL_W-1:0]         curLevel,
  output logic                     winValid,
  output logic [IDX_W-1:0]         winIdx,
  output logic [LVL_W-1:0]         winLevel
);

  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winLevel = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (reqLines[i] && (reqLevels[i*LVL_W +: LVL_W] > curLevel) &&
          (!winValid || (reqLevels[i*LVL_W +: LVL_W] >= winLevel))) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winLevel = reqLevels[i*LVL_W +: LVL_W];
      end
    end
  end

endmodule

// File: rtl/irq_seq_ctrl.sv
`timescale 1ns/1ps
module irq_seq_ctrl
  import irq_accept_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      winValid,
  input  logic      retReq,
  input  logic      stackEmpty,
  output dpStrobe_t strb
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      SEQ_IDLE: begin
        if (retReq && !stackEmpty) begin
          nextState = SEQ_POP_PC;
        end else if (winValid) begin
          strb.latchWin = 1'b1;
          nextState     = SEQ_PUSH_ST;
        end
      end
      SEQ_PUSH_ST: begin
        strb.pushSt = 1'b1;
        nextState   = SEQ_PUSH_PC;
      end
      SEQ_PUSH_PC: begin
        strb.pushPc = 1'b1;
        nextState   = SEQ_IDLE;
      end
      SEQ_POP_PC: begin
        strb.popPc = 1'b1;
        nextState  = SEQ_POP_ST;
      end
      SEQ_POP_ST: begin
        strb.popSt = 1'b1;
        nextState  = SEQ_IDLE;
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

endmodule

// File: rtl/irq_datapath.sv
`timescale 1ns/1ps
module irq_datapath
  import irq_accept_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int LVL_W     = 3,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int STACK_TOP = 'h100,
  localparam int IDX_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int FLAG_W   = DATA_W - LVL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  dpStrobe_t                 strb,
  input  logic [IDX_W-1:0]          winIdx,
  input  logic [LVL_W-1:0]          winLevel,
  input  logic [NUM_DEV*ADDR_W-1:0] devVectors,
  input  logic [ADDR_W-1:0]         pcIn,
  input  logic [FLAG_W-1:0]         coreFlags,
  input  logic [DATA_W-1:0]         stkRData,
  output logic                      stackEmpty,
  output logic [NUM_DEV-1:0]        ackOut,
  output logic [ADDR_W-1:0]         vectorOut,
  output logic                      enterPulse,
  output logic [LVL_W-1:0]          curLevel,
  output logic                      stkWe,
  output logic                      stkRe,
  output logic [ADDR_W-1:0]         stkAddr,
  output logic [DATA_W-1:0]         stkWData,
  output logic                      retDone,
  output logic [ADDR_W-1:0]         retPc,
  output logic [DATA_W-1:0]         retStatus
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(STACK_TOP);

  logic [ADDR_W-1:0] sp;
  logic [LVL_W-1:0]  pendLevel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp         <= TOP_ADDR;
      curLevel   <= '0;
      pendLevel  <= '0;
      vectorOut  <= '0;
      ackOut     <= '0;
      enterPulse <= 1'b0;
      retDone    <= 1'b0;
      retPc      <= '0;
      retStatus  <= '0;
    end else begin
      ackOut     <= strb.latchWin ? (NUM_DEV'(1) << winIdx) : '0;
      enterPulse <= strb.pushPc;
      retDone    <= strb.popSt;
      if (strb.latchWin) begin
        vectorOut <= devVectors[int'(winIdx)*ADDR_W +: ADDR_W];
        pendLevel <= winLevel;
      end
      if (strb.pushSt || strb.pushPc) sp <= sp - 1'b1;
      if (strb.popPc  || strb.popSt)  sp <= sp + 1'b1;
      if (strb.pushPc) curLevel <= pendLevel;
      if (strb.popPc)  retPc    <= stkRData[ADDR_W-1:0];
      if (strb.popSt) begin
        retStatus <= stkRData;
        curLevel  <= stkRData[LVL_W-1:0];
      end
    end
  end

  always_comb begin
    stackEmpty = (sp == TOP_ADDR);
    stkWe      = strb.pushSt | strb.pushPc;
    stkRe      = strb.popPc | strb.popSt;
    stkAddr    = stkWe ? (sp - 1'b1) : sp;
    stkWData   = strb.pushSt ? {coreFlags, curLevel} : DATA_W'(pcIn);
  end

endmodule

// File: rtl/irq_accept_top.sv
`timescale 1ns/1ps
module irq_accept_top
  import irq_accept_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int LVL_W     = 3,
  parameter int MAX_LEVEL = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int STACK_TOP = 'h100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_DEV-1:0]        reqLines,
  input  logic [NUM_DEV*LVL_W-1:0]  reqLevels,
  input  logic [NUM_DEV*ADDR_W-1:0] devVectors,
  input  logic [ADDR_W-1:0]         pcIn,
  input  logic [DATA_W-LVL_W-1:0]   coreFlags,
  input  logic                      retReq,
  output logic [NUM_DEV-1:0]        ackOut,
  output logic [ADDR_W-1:0]         vectorOut,
  output logic                      enterPulse,
  output logic [LVL_W-1:0]          curLevel,
  output logic                      stkWe,
  output logic                      stkRe,
  output logic [ADDR_W-1:0]         stkAddr,
  output logic [DATA_W-1:0]         stkWData,
  input  logic [DATA_W-1:0]         stkRData,
  output logic                      retDone,
  output logic [ADDR_W-1:0]         retPc,
  output logic [DATA_W-1:0]         retStatus
);

  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             winValid;
  logic [IDX_W-1:0] winIdx;
  logic [LVL_W-1:0] winLevel;
  logic             stackEmpty;
  dpStrobe_t        strb;

  irq_arbiter #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_arb (
    .reqLines(reqLines), .reqLevels(reqLevels), .curLevel(curLevel),
    .winValid(winValid), .winIdx(winIdx), .winLevel(winLevel)
  );

  irq_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .winValid(winValid), .retReq(retReq),
    .stackEmpty(stackEmpty), .strb(strb)
  );

  irq_datapath #(
    .NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .STACK_TOP(STACK_TOP)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .winIdx(winIdx), .winLevel(winLevel),
    .devVectors(devVectors), .pcIn(pcIn), .coreFlags(coreFlags),
    .stkRData(stkRData), .stackEmpty(stackEmpty), .ackOut(ackOut),
    .vectorOut(vectorOut), .enterPulse(enterPulse), .curLevel(curLevel),
    .stkWe(stkWe), .stkRe(stkRe), .stkAddr(stkAddr), .stkWData(stkWData),
    .retDone(retDone), .retPc(retPc), .retStatus(retStatus)
  );

endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk #(
  parameter int NUM_DEV   = 4,
  parameter int LVL_W     = 3,
  parameter int MAX_LEVEL = 4,
  parameter int ADDR_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] ackOut,
  input logic               enterPulse,
  input logic               retDone,
  input logic [LVL_W-1:0]   curLevel,
  input logic               stkWe,
  input logic               stkRe,
  input logic [ADDR_W-1:0]  stkAddr
);

  // R4
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ackOut));

  // R5
  ack_with_status_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ackOut) |-> (stkWe && !stkRe));

  // R5
  push_downward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stkWe && $past(stkWe)) |-> (stkAddr == $past(stkAddr) - 1'b1));

  // R6
  entry_raises_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enterPulse |-> (curLevel > $past(curLevel)));

  // R10
  level_moves_only_at_seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(curLevel) |-> (enterPulse || retDone));

  // R2
  level_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    curLevel <= LVL_W'(MAX_LEVEL));

endmodule

bind irq_accept_top irq_accept_chk #(
  .NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .MAX_LEVEL(MAX_LEVEL), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ackOut(ackOut), .enterPulse(enterPulse),
  .retDone(retDone), .curLevel(curLevel), .stkWe(stkWe), .stkRe(stkRe),
  .stkAddr(stkAddr)
);

// File: tb/irq_accept_top_tb.sv
`timescale 1ns/1ps
module irq_accept_top_tb;
  localparam int NUM_DEV = 4;
  localparam int LVL_W   = 3;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int TOP     = 'h100;
  localparam int FLAG_W  = DATA_W - LVL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_DEV-1:0]        reqLines = '0;
  logic [NUM_DEV*LVL_W-1:0]  reqLevels;
  logic [NUM_DEV*ADDR_W-1:0] devVectors;
  logic [ADDR_W-1:0]         pcIn = '0;
  logic [FLAG_W-1:0]         coreFlags = 13'h0A5A;
  logic                      retReq = 1'b0;
  logic [NUM_DEV-1:0]        ackOut;
  logic [ADDR_W-1:0]         vectorOut;
  logic                      enterPulse;
  logic [LVL_W-1:0]          curLevel;
  logic                      stkWe, stkRe;
  logic [ADDR_W-1:0]         stkAddr;
  logic [DATA_W-1:0]         stkWData, stkRData;
  logic                      retDone;
  logic [ADDR_W-1:0]         retPc;
  logic [DATA_W-1:0]         retStatus;

  int lv  [NUM_DEV];
  int vec [NUM_DEV];

  always_comb begin
    for (int i = 0; i < NUM_DEV; i++) begin
      reqLevels[i*LVL_W +: LVL_W]   = LVL_W'(lv[i]);
      devVectors[i*ADDR_W +: ADDR_W] = ADDR_W'(vec[i]);
    end
  end

  always #4 clk = ~clk;

  irq_accept_top u_dut (
    .clk(clk), .rst_n(rst_n), .reqLines(reqLines), .reqLevels(reqLevels),
    .devVectors(devVectors), .pcIn(pcIn), .coreFlags(coreFlags), .retReq(retReq),
    .ackOut(ackOut), .vectorOut(vectorOut), .enterPulse(enterPulse),
    .curLevel(curLevel), .stkWe(stkWe), .stkRe(stkRe), .stkAddr(stkAddr),
    .stkWData(stkWData), .stkRData(stkRData), .retDone(retDone),
    .retPc(retPc), .retStatus(retStatus)
  );

  // stack storage seen by the design
  logic [DATA_W-1:0] tbMem [256];
  always @(posedge clk) if (stkWe) tbMem[stkAddr[7:0]] <= stkWData;
  assign stkRData = tbMem[stkAddr[7:0]];

  int nChecks = 0;
  int nFail   = 0;
  bit running = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  int mPhase, mLevel, mSp, mWin, mVec, mRetPc, mRetSt, best;
  int mMem [256];
  bit mEnter, mRet;
  int mAck;

  always @(posedge clk) begin
    if (!rst_n) begin
      mPhase = 0; mLevel = 0; mSp = TOP; mAck = 0; mEnter = 0; mRet = 0;
      mRetPc = 0; mRetSt = 0; mVec = 0;
    end else begin
      mAck = 0; mEnter = 0; mRet = 0;
      case (mPhase)
        0: begin
          if (retReq && mSp != TOP) mPhase = 3;
          else begin
            best = -1;
            for (int i = 0; i < NUM_DEV; i++)
              if (reqLines[i] && lv[i] > mLevel && (best < 0 || lv[i] > lv[best])) best = i;
            if (best >= 0) begin
              mAck = 1 << best; mVec = vec[best]; mWin = lv[best]; mPhase = 1;
            end
          end
        end
        1: begin mMem[(mSp-1) & 255] = (int'(coreFlags) << LVL_W) | mLevel; mSp--; mPhase = 2; end
        2: begin mMem[(mSp-1) & 255] = int'(pcIn); mSp--; mLevel = mWin; mEnter = 1; mPhase = 0; end
        3: begin mRetPc = mMem[mSp & 255]; mSp++; mPhase = 4; end
        default: begin
          mRetSt = mMem[mSp & 255]; mLevel = mRetSt & 7; mSp++; mRet = 1; mPhase = 0;
        end
      endcase
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      check(int'(curLevel) == mLevel, "R6 curLevel", curLevel, mLevel);
      check(int'(ackOut) == mAck, "R4 ackOut", ackOut, mAck);
      check(enterPulse == mEnter, "R6 enterPulse", enterPulse, mEnter);
      if (mEnter) check(int'(vectorOut) == mVec, "R6 vectorOut", vectorOut, mVec);
      check(stkWe == (mPhase == 1 || mPhase == 2), "R5 stkWe", stkWe, (mPhase == 1 || mPhase == 2));
      check(stkRe == (mPhase == 3 || mPhase == 4), "R7 stkRe", stkRe, (mPhase == 3 || mPhase == 4));
      if (mPhase == 1 || mPhase == 2)
        check(int'(stkAddr) == mSp - 1, "R5 stkAddr", stkAddr, mSp - 1);
      if (mPhase == 3 || mPhase == 4)
        check(int'(stkAddr) == mSp, "R7 stkAddr", stkAddr, mSp);
      if (mPhase == 1) begin
        check(int'(stkWData) == ((int'(coreFlags) << LVL_W) | mLevel), "R5 status word",
              stkWData, (int'(coreFlags) << LVL_W) | mLevel);
      end
      if (mPhase == 2) check(stkWData == DATA_W'(pcIn), "R5 pc word", stkWData, pcIn);
      check(retDone == mRet, "R7 retDone", retDone, mRet);
      if (mRet) begin
        check(int'(retPc) == mRetPc, "R7 retPc", retPc, mRetPc);
        check(int'(retStatus) == mRetSt, "R7 retStatus", retStatus, mRetSt);
      end
    end
  end

  // one cycle; devices drop their line once acknowledged
  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqLines = reqLines & ~ackOut;
    end
  endtask

  task automatic doReturn();
    retReq = 1'b1;
    step();
    retReq = 1'b0;
    step(3);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < NUM_DEV; i++) begin lv[i] = 0; vec[i] = 'h1000 + i * 'h40; end
    step(3);
    // R1 reset state
    check(curLevel == 0, "R1 curLevel", curLevel, 0);
    check(ackOut == 0 && !stkWe && !stkRe, "R1 idle strobes", {ackOut, stkWe, stkRe}, 0);
    rst_n = 1'b1;
    running = 1'b1;
    step();

    // R1 / R6: first accept at level 2, first push at STACK_TOP-1
    lv[1] = 2; pcIn = 'h0200; reqLines[1] = 1'b1;
    step();
    check(ackOut == 4'b0010, "R4 ack dev1", ackOut, 4'b0010);
    check(vectorOut == 16'h1040, "R4 vector latched", vectorOut, 16'h1040);
    check(stkWe && stkAddr == 16'h00FF, "R1 first push addr", stkAddr, 16'h00FF);
    step();
    check(ackOut == 0, "R4 ack one cycle", ackOut, 0);
    step();
    check(enterPulse && curLevel == 2, "R6 level after entry", curLevel, 2);
    check(tbMem[8'hFF] == {coreFlags, 3'd0}, "R5 status stored", tbMem[8'hFF], {coreFlags, 3'd0});
    check(tbMem[8'hFE] == 16'h0200, "R5 pc stored", tbMem[8'hFE], 16'h0200);

    // R2: equal and lower levels stay pending
    lv[0] = 2; lv[2] = 1; reqLines[0] = 1'b1; reqLines[2] = 1'b1;
    step(5);
    check(curLevel == 2 && reqLines[2:0] == 3'b101, "R2 equal/lower pending", {curLevel, reqLines}, {3'd2, 4'b0101});
    reqLines[2] = 1'b0;

    // R2 preempt with higher; R10 no decision mid-entry
    lv[3] = 4; pcIn = 'h0300; reqLines[3] = 1'b1;
    step();
    check(ackOut == 4'b1000, "R2 higher preempts", ackOut, 4'b1000);
    step(2);
    check(curLevel == 4, "R2 nested level", curLevel, 4);

    // R7 return to level 2, dev0 (level 2) still blocked
    doReturn();
    check(curLevel == 2 && retPc == 16'h0300, "R7 restore", {curLevel, retPc}, {3'd2, 16'h0300});
    step(2);
    check(ackOut == 0 && reqLines[0], "R2 same level still blocked", ackOut, 0);

    // R9: return together with an eligible level-3 request
    lv[2] = 3; reqLines[2] = 1'b1; retReq = 1'b1;
    step();
    retReq = 1'b0;
    check(stkRe && ackOut == 0, "R9 return first", {stkRe, ackOut}, {1'b1, 4'b0000});
    step(3);
    check(ackOut == 4'b0100, "R3 level 3 beats level 2", ackOut, 4'b0100);
    step(2);
    check(curLevel == 3, "R9 level after", curLevel, 3);
    doReturn();
    step(3);
    check(curLevel == 2 && !reqLines[0], "R7 dev0 taken after return", curLevel, 2);
    doReturn();
    check(curLevel == 0, "R7 back to 0", curLevel, 0);

    // R3 tie: two level-3 requests, lowest index wins
    lv[1] = 3; lv[2] = 3; reqLines[2:1] = 2'b11;
    step();
    check(ackOut == 4'b0010, "R3 tie lowest index", ackOut, 4'b0010);
    // R10: a level-4 request raised during the entry waits for idle
    reqLines[3] = 1'b1;
    step();
    check(ackOut == 0, "R10 no ack mid-entry", ackOut, 0);
    step(2);
    check(ackOut == 4'b1000, "R10 ack after idle", ackOut, 4'b1000);
    step(3);
    doReturn();
    step(3);
    check(ackOut == 0 && reqLines[2], "R2 tie loser blocked at level 3", {ackOut, reqLines}, 0);
    doReturn();
    step(4);
    doReturn();
    check(curLevel == 0, "R7 unwound", curLevel, 0);

    // R2: level-0 request never accepted
    lv[0] = 0; reqLines[0] = 1'b1;
    step(4);
    check(ackOut == 0 && curLevel == 0, "R2 level 0 ignored", ackOut, 0);
    reqLines[0] = 1'b0;

    // R8: return on empty stack ignored
    retReq = 1'b1;
    step();
    retReq = 1'b0;
    check(!stkRe, "R8 no read on empty", stkRe, 0);
    step(3);
    check(!retDone && curLevel == 0, "R8 no return", retDone, 0);

    running = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule